// File: doc/BRIEF.md
# Multichannel Circular Buffer Controller

This block manages eight ring buffers that share one external memory bank, one region per acquisition channel. Each channel owns a write pointer, advanced whenever a captured sample is committed to memory, and a read pointer, advanced by a DMA consumer through a small register port. Samples land in a one-word holding slot per channel. A round-robin arbiter drains the slots into a single request/grant memory write port, one word per grant.

Every stored word carries a timestamp made of a macro-cycle count and the sample index within that cycle. Both are taken in the clock cycle in which the sample was accepted, so the tag is exact to one clock. Two faults are tracked apart, each as a sticky per-channel flag. An overflow means a sample arrived while its channel's slot was still waiting for memory. An overwrite means the writer lapped unread data. On an overwrite the read pointer in force is saved for later diagnosis, and the read pointer moves on by one word.

Top module: `ringbuf_ctrl`

## Requirements
- R1: After reset every write pointer, read pointer and saved lap pointer reads 0, all overflow and overwrite flags are 0, and mem_req is low.
- R2: The memory port serves pending channels round-robin. The channel served next is the first pending one counting upward, cyclically, from the channel last served, and the search starts at channel 0 after reset. While mem_req is high and mem_gnt is low, mem_addr and mem_wdata hold steady. Each cycle with mem_req and mem_gnt both high commits exactly one word.
- R3: mem_addr is {channel, low PTR_W bits of that channel's write pointer}. Pointers are PTR_W+1 bits wide, and each committed word advances its channel's write pointer by one, modulo 2^(PTR_W+1).
- R4: mem_wdata is {macro-cycle count [47:32], sample index [31:16], sample data [15:0]}, holding the counter values of the cycle in which the sample was accepted. A cycle with sync_in high makes the next cycle carry macro-cycle count + 1 and sample index 0. Otherwise the sample index grows by one each clock.
- R5: A sample is dropped, and the channel's overflow flag set, when it arrives while that channel's slot is full and not being committed in the same cycle. A slot committed in the same cycle takes the new sample with no overflow.
- R6: A commit to a channel whose buffer is full (write minus read pointer equals 2^PTR_W) sets its overwrite flag, saves the old read pointer as the lap pointer, and moves the read pointer to old value + 1.
- R7: A consumer write of value V to a channel's read pointer R takes effect only when (V - R) mod 2^(PTR_W+1) is at most (W - R) mod 2^(PTR_W+1), where W is the write pointer. Otherwise it is ignored.
- R8: With clr_en high, each bit set in clr_ovf_mask or clr_ovw_mask clears that channel's flag. Flags whose mask bit is 0 are untouched, and a fault in the same cycle wins over the clear.
- R9: Overflow and overwrite flags stay set until cleared as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Macro-cycle start pulse |
| in_valid | input | N_CH | Per-channel sample strobe |
| in_data | input | N_CH*DATA_W | Per-channel sample data, channel c at bits [c*DATA_W +: DATA_W] |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory write grant |
| mem_addr | output | CH_W+PTR_W | Memory word address |
| mem_wdata | output | CYC_W+SMP_W+DATA_W | Timestamped word |
| rp_wr_en | input | 1 | Read pointer write strobe |
| rp_wr_ch | input | CH_W | Channel of the read pointer write |
| rp_wr_val | input | PTR_W+1 | New read pointer value |
| clr_en | input | 1 | Flag clear strobe |
| clr_ovf_mask | input | N_CH | Overflow flags to clear |
| clr_ovw_mask | input | N_CH | Overwrite flags to clear |
| ovf_flags | output | N_CH | Sticky overflow flags |
| ovw_flags | output | N_CH | Sticky overwrite flags |
| stat_sel | input | CH_W | Channel selected for pointer readback |
| stat_wptr | output | PTR_W+1 | Write pointer of the selected channel |
| stat_rptr | output | PTR_W+1 | Read pointer of the selected channel |
| stat_lap_rptr | output | PTR_W+1 | Saved lap pointer of the selected channel |

## Verification
Arbitration is driven with three request sets. The first holds four channels while the grant is low. The second starts just after the ring wraps, and in the third a high channel is served before a low one, which separates true rotation from fixed priority. Timestamps are checked across two sync pulses with samples a few clocks apart, which exposes any off-by-one in when the tag is taken. Faults are provoked by a second sample on a blocked slot, by a steady stream at the highest sustainable rate (which must not flag), and by filling one channel to the brim and one word more. Consumer pointer writes are tried inside the valid window, exactly at its end, and just past it.

// File: rtl/ringbuf_pkg.sv
package ringbuf_pkg;
  localparam int unsigned RB_N_CH   = 8;
  localparam int unsigned RB_PTR_W  = 4;
  localparam int unsigned RB_DATA_W = 16;
  localparam int unsigned RB_CYC_W  = 16;
  localparam int unsigned RB_SMP_W  = 16;
endpackage

// File: rtl/ringbuf_rst_sync.sv
module ringbuf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_s = sh_q[1];
endmodule

// File: rtl/ringbuf_tstamp.sv
module ringbuf_tstamp #(
  parameter int unsigned CYC_W = 16,
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  output logic [CYC_W-1:0] cyc,
  output logic [SMP_W-1:0] smp
);
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic             cyc_en;

  always_comb begin
    cyc_en = sync_in;
    cyc_d  = cyc_q + CYC_W'(1);
    smp_d  = sync_in ? '0 : smp_q + SMP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      smp_q <= '0;
    end else begin
      if (cyc_en) cyc_q <= cyc_d;
      smp_q <= smp_d;
    end
  end

  assign cyc = cyc_q;
  assign smp = smp_q;
endmodule

// File: rtl/ringbuf_rr_arb.sv
module ringbuf_rr_arb #(
  parameter int unsigned N_CH = 8,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] req,
  input  logic [CH_W-1:0] last,
  output logic            any,
  output logic [CH_W-1:0] pick
);
  // Rotating search: first requester strictly after 'last', wrapping.
  always_comb begin
    any  = 1'b0;
    pick = last;
    for (int i = 1; i <= int'(N_CH); i++) begin
      int j;
      j = (int'(last) + i) % int'(N_CH);
      if (!any && req[j]) begin
        any  = 1'b1;
        pick = CH_W'(j);
      end
    end
  end
endmodule

// File: rtl/ringbuf_chan.sv
module ringbuf_chan #(
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned WORD_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              commit,
  input  logic              rp_wr,
  input  logic [PTR_W:0]    rp_val,
  input  logic              clr_ovf,
  input  logic              clr_ovw,
  output logic              hold_v,
  output logic [WORD_W-1:0] hold_word,
  output logic [PTR_W:0]    wptr,
  output logic [PTR_W:0]    rptr,
  output logic [PTR_W:0]    lap_rptr,
  output logic              ovf,
  output logic              ovw
);
  localparam logic [PTR_W:0] DEPTH = {1'b1, {PTR_W{1'b0}}};

  logic              hv_q, hv_d, hv_en;
  logic [WORD_W-1:0] hw_q;
  logic [PTR_W:0]    wp_q, wp_d, rp_q, rp_d, lap_q;
  logic              wp_en, rp_en, lap_en;
  logic              ovf_q, ovf_d, ovf_en, ovw_q, ovw_d, ovw_en;
  logic              accept, drop, lap;
  logic [PTR_W:0]    fill, rp_off;
  logic              rp_ok;

  always_comb begin
    accept = in_valid && (!hv_q || commit);
    drop   = in_valid && hv_q && !commit;
    fill   = wp_q - rp_q;
    rp_off = rp_val - rp_q;
    lap    = commit && (fill == DEPTH);
    // A lap in the same cycle takes precedence over a consumer write.
    rp_ok  = rp_wr && (rp_off <= fill) && !lap;

    hv_en  = accept || commit;
    hv_d   = accept;
    wp_en  = commit;
    wp_d   = wp_q + 1'b1;
    rp_en  = lap || rp_ok;
    rp_d   = lap ? rp_q + 1'b1 : rp_val;
    lap_en = lap;
    ovf_en = drop || clr_ovf;
    ovf_d  = drop;
    ovw_en = lap || clr_ovw;
    ovw_d  = lap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q  <= 1'b0;
      hw_q  <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      lap_q <= '0;
      ovf_q <= 1'b0;
      ovw_q <= 1'b0;
    end else begin
      if (hv_en)  hv_q  <= hv_d;
      if (accept) hw_q  <= in_word;
      if (wp_en)  wp_q  <= wp_d;
      if (rp_en)  rp_q  <= rp_d;
      if (lap_en) lap_q <= rp_q;
      if (ovf_en) ovf_q <= ovf_d;
      if (ovw_en) ovw_q <= ovw_d;
    end
  end

  assign hold_v    = hv_q;
  assign hold_word = hw_q;
  assign wptr      = wp_q;
  assign rptr      = rp_q;
  assign lap_rptr  = lap_q;
  assign ovf       = ovf_q;
  assign ovw       = ovw_q;
endmodule

// File: rtl/ringbuf_ctrl.sv
module ringbuf_ctrl
  import ringbuf_pkg::*;
#(
  parameter int unsigned N_CH   = RB_N_CH,
  parameter int unsigned PTR_W  = RB_PTR_W,
  parameter int unsigned DATA_W = RB_DATA_W,
  parameter int unsigned CYC_W  = RB_CYC_W,
  parameter int unsigned SMP_W  = RB_SMP_W,
  localparam int unsigned CH_W   = $clog2(N_CH),
  localparam int unsigned WORD_W = CYC_W + SMP_W + DATA_W
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   sync_in,
  input  logic [N_CH-1:0]        in_valid,
  input  logic [N_CH*DATA_W-1:0] in_data,
  output logic                   mem_req,
  input  logic                   mem_gnt,
  output logic [CH_W+PTR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]      mem_wdata,
  input  logic                   rp_wr_en,
  input  logic [CH_W-1:0]        rp_wr_ch,
  input  logic [PTR_W:0]         rp_wr_val,
  input  logic                   clr_en,
  input  logic [N_CH-1:0]        clr_ovf_mask,
  input  logic [N_CH-1:0]        clr_ovw_mask,
  output logic [N_CH-1:0]        ovf_flags,
  output logic [N_CH-1:0]        ovw_flags,
  input  logic [CH_W-1:0]        stat_sel,
  output logic [PTR_W:0]         stat_wptr,
  output logic [PTR_W:0]         stat_rptr,
  output logic [PTR_W:0]         stat_lap_rptr
);
  logic             rst_n_s;
  logic [CYC_W-1:0] ts_cyc;
  logic [SMP_W-1:0] ts_smp;

  logic [N_CH-1:0]   hold_v;
  logic [WORD_W-1:0] hold_word [N_CH];
  logic [PTR_W:0]    wptr_a [N_CH];
  logic [PTR_W:0]    rptr_a [N_CH];
  logic [PTR_W:0]    lap_a  [N_CH];

  logic            busy_q, busy_d, sel_en, commit;
  logic [CH_W-1:0] cur_q, cur_d;
  logic [N_CH-1:0] commit_vec, req_eff;
  logic            arb_any;
  logic [CH_W-1:0] arb_pick;

  ringbuf_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_s(rst_n_s));

  ringbuf_tstamp #(.CYC_W(CYC_W), .SMP_W(SMP_W)) u_ts (
    .clk(clk), .rst_n(rst_n_s), .sync_in(sync_in), .cyc(ts_cyc), .smp(ts_smp)
  );

  for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
    ringbuf_chan #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .in_valid (in_valid[c]),
      .in_word  ({ts_cyc, ts_smp, in_data[c*DATA_W +: DATA_W]}),
      .commit   (commit_vec[c]),
      .rp_wr    (rp_wr_en && (rp_wr_ch == CH_W'(c))),
      .rp_val   (rp_wr_val),
      .clr_ovf  (clr_en && clr_ovf_mask[c]),
      .clr_ovw  (clr_en && clr_ovw_mask[c]),
      .hold_v   (hold_v[c]),
      .hold_word(hold_word[c]),
      .wptr     (wptr_a[c]),
      .rptr     (rptr_a[c]),
      .lap_rptr (lap_a[c]),
      .ovf      (ovf_flags[c]),
      .ovw      (ovw_flags[c])
    );
  end

  ringbuf_rr_arb #(.N_CH(N_CH)) u_arb (
    .req(req_eff), .last(cur_q), .any(arb_any), .pick(arb_pick)
  );

  // Next-state for the single outstanding memory request.
  always_comb begin
    commit     = busy_q && mem_gnt;
    commit_vec = commit ? (N_CH'(1) << cur_q) : '0;
    req_eff    = hold_v & ~commit_vec;
    sel_en     = !busy_q || commit;
    busy_d     = arb_any;
    cur_d      = arb_pick;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      cur_q  <= CH_W'(N_CH - 1);
    end else begin
      if (sel_en)            busy_q <= busy_d;
      if (sel_en && arb_any) cur_q  <= cur_d;
    end
  end

  assign mem_req       = busy_q;
  assign mem_addr      = {cur_q, wptr_a[cur_q][PTR_W-1:0]};
  assign mem_wdata     = hold_word[cur_q];
  assign stat_wptr     = wptr_a[stat_sel];
  assign stat_rptr     = rptr_a[stat_sel];
  assign stat_lap_rptr = lap_a[stat_sel];
endmodule

// File: rtl/ringbuf_ctrl_chk.sv
module ringbuf_ctrl_chk #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned AW     = 7,
  parameter int unsigned WW     = 48,
  parameter int unsigned SMP_W  = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_gnt,
  input logic [AW-1:0]   mem_addr,
  input logic [WW-1:0]   mem_wdata,
  input logic            sync_in,
  input logic [SMP_W-1:0] smp,
  input logic            clr_en,
  input logic [N_CH-1:0] ovf_flags,
  input logic [N_CH-1:0] ovw_flags
);
  // R2: a waiting request keeps address and data
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  // R3: the word after a commit never reuses the same address
  a_r3_addr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> !mem_req || (mem_addr != $past(mem_addr)));

  // R4: sample index steps by one between sync pulses
  a_r4_smp_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_in |=> smp == SMP_W'($past(smp) + 1'b1));

  // R4: sample index restarts after a sync pulse
  a_r4_smp_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> smp == '0);

  // R9: overflow flags never drop without a clear
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ($past(ovf_flags) & ~ovf_flags) == '0);

  // R9: overwrite flags never drop without a clear
  a_r9_ovw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ($past(ovw_flags) & ~ovw_flags) == '0);
endmodule

bind ringbuf_ctrl ringbuf_ctrl_chk #(
  .N_CH(N_CH), .AW(CH_W + PTR_W), .WW(WORD_W), .SMP_W(SMP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n_s), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sync_in(sync_in),
  .smp(ts_smp), .clr_en(clr_en), .ovf_flags(ovf_flags), .ovw_flags(ovw_flags)
);

// File: tb/ringbuf_ctrl_tb_top.sv
module ringbuf_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8, PW = 4, DW = 16, CW = 16, SW = 16;
  localparam int AW = 3 + PW, WW = CW + SW + DW;

  logic clk = 1'b0;
  logic arst_n, sync_in, mem_gnt, rp_wr_en, clr_en;
  logic [NCH-1:0] in_valid, clr_ovf_mask, clr_ovw_mask, ovf_flags, ovw_flags;
  logic [NCH*DW-1:0] in_data;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic [2:0] rp_wr_ch, stat_sel;
  logic [PW:0] rp_wr_val, stat_wptr, stat_rptr, stat_lap_rptr;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  logic [AW-1:0] log_a [0:255];
  logic [WW-1:0] log_d [0:255];
  int log_n = 0;

  ringbuf_ctrl dut_i (
    .clk(clk), .arst_n(arst_n), .sync_in(sync_in), .in_valid(in_valid),
    .in_data(in_data), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rp_wr_en(rp_wr_en),
    .rp_wr_ch(rp_wr_ch), .rp_wr_val(rp_wr_val), .clr_en(clr_en),
    .clr_ovf_mask(clr_ovf_mask), .clr_ovw_mask(clr_ovw_mask),
    .ovf_flags(ovf_flags), .ovw_flags(ovw_flags), .stat_sel(stat_sel),
    .stat_wptr(stat_wptr), .stat_rptr(stat_rptr), .stat_lap_rptr(stat_lap_rptr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory side: record every word committed at the coming edge.
  always @(negedge clk) begin
    if (mem_req === 1'b1 && mem_gnt === 1'b1 && log_n < 256) begin
      log_a[log_n] = mem_addr;
      log_d[log_n] = mem_wdata;
      log_n++;
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog (all R): cycles=%0d expected<=20000", n_cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input int ch, input logic [DW-1:0] d);
    in_valid[ch] = 1'b1;
    in_data[ch*DW +: DW] = d;
    step();
    in_valid = '0;
  endtask

  task automatic push_set(input logic [NCH-1:0] m, input logic [DW-1:0] base);
    for (int c = 0; c < NCH; c++) in_data[c*DW +: DW] = base + DW'(c);
    in_valid = m;
    step();
    in_valid = '0;
  endtask

  task automatic rd_stat(input int ch, output logic [PW:0] w, output logic [PW:0] r,
                         output logic [PW:0] l);
    stat_sel = 3'(ch);
    #1;
    w = stat_wptr; r = stat_rptr; l = stat_lap_rptr;
  endtask

  task automatic rp_write(input int ch, input logic [PW:0] v);
    rp_wr_en = 1'b1; rp_wr_ch = 3'(ch); rp_wr_val = v;
    step();
    rp_wr_en = 1'b0;
  endtask

  task automatic clear(input logic [NCH-1:0] om, input logic [NCH-1:0] wm);
    clr_en = 1'b1; clr_ovf_mask = om; clr_ovw_mask = wm;
    step();
    clr_en = 1'b0; clr_ovf_mask = '0; clr_ovw_mask = '0;
  endtask

  task automatic t_reset();
    logic [PW:0] w, r, l;
    chk(64'(mem_req), 0, "R1 mem_req");
    chk(64'(ovf_flags), 0, "R1 ovf");
    chk(64'(ovw_flags), 0, "R1 ovw");
    for (int c = 0; c < NCH; c++) begin
      rd_stat(c, w, r, l);
      chk(64'({w, r, l}), 0, "R1 pointers");
    end
  endtask

  task automatic t_rr();
    int n0;
    logic [AW-1:0] a0;
    int exp1 [4] = '{0, 2, 5, 7};
    logic [PW:0] w, r, l;
    mem_gnt = 1'b0;
    n0 = log_n;
    push_set(8'b1010_0101, 16'hA000);
    step(); step();
    chk(64'(mem_req), 1, "R2 request raised");
    chk(64'(mem_addr), 64'(7'h00), "R2 first pick ch0");
    a0 = mem_addr;
    step();
    chk(64'({mem_req, mem_addr}), 64'({1'b1, a0}), "R2 held while not granted");
    mem_gnt = 1'b1;
    repeat (10) step();
    chk(64'(log_n - n0), 4, "R2 one word per grant");
    for (int k = 0; k < 4; k++) begin
      chk(64'(log_a[n0+k]), 64'(exp1[k] << PW), "R2 R3 order and address");
      chk(64'(log_d[n0+k][DW-1:0]), 64'(16'hA000 + exp1[k]), "R2 data");
    end
    n0 = log_n;
    push_set(8'b0001_0010, 16'hB000);
    repeat (8) step();
    chk(64'(log_a[n0] >> PW), 1, "R2 wrap to ch1");
    chk(64'(log_a[n0+1] >> PW), 4, "R2 then ch4");
    n0 = log_n;
    push_set(8'b0100_0100, 16'hC000);
    repeat (8) step();
    chk(64'(log_a[n0]), 64'({3'd6, 4'd0}), "R2 rotation ch6 before ch2");
    chk(64'(log_a[n0+1]), 64'({3'd2, 4'd1}), "R3 ch2 second word at 1");
    rd_stat(2, w, r, l);
    chk(64'(w), 2, "R3 ch2 wptr");
  endtask

  task automatic t_tstamp();
    int n0;
    logic [CW-1:0] c0;
    n0 = log_n;
    sync_in = 1'b1; step(); sync_in = 1'b0;
    push(1, 16'h1111);
    step(); step();
    push(4, 16'h4444);
    repeat (6) step();
    c0 = log_d[n0][47:32];
    chk(64'(log_d[n0][31:0]), 64'({16'd0, 16'h1111}), "R4 index 0 after sync");
    chk(64'(log_d[n0+1]), 64'({c0, 16'd3, 16'h4444}), "R4 index 3, same cycle");
    n0 = log_n;
    sync_in = 1'b1; step(); sync_in = 1'b0;
    push(5, 16'h5555);
    repeat (6) step();
    chk(64'(log_d[n0]), 64'({CW'(c0 + 1'b1), 16'd0, 16'h5555}), "R4 macro-cycle step");
  endtask

  task automatic t_ovf();
    int n0, cnt;
    mem_gnt = 1'b0;
    n0 = log_n;
    push(4, 16'h4001);
    push(4, 16'h4002);
    chk(64'(ovf_flags), 64'(8'h10), "R5 drop on ch4");
    push(5, 16'h5001);
    push(5, 16'h5002);
    chk(64'(ovf_flags), 64'(8'h30), "R5 drop on ch5");
    mem_gnt = 1'b1;
    repeat (8) step();
    cnt = 0;
    for (int k = n0; k < log_n; k++)
      if ((log_a[k] >> PW) == 4) begin
        cnt++;
        chk(64'(log_d[k][DW-1:0]), 64'(16'h4001), "R5 first sample kept");
      end
    chk(64'(cnt), 1, "R5 one ch4 word");
    repeat (3) step();
    chk(64'(ovf_flags), 64'(8'h30), "R9 flags stay set");
    clear(8'h10, 8'h00);
    chk(64'(ovf_flags), 64'(8'h20), "R8 only masked bit cleared");
    clear(8'h20, 8'h00);
    n0 = log_n;
    for (int k = 0; k < 6; k++) begin
      push(3, DW'(16'h3000 + k));
      step();
    end
    repeat (6) step();
    chk(64'(ovf_flags), 0, "R5 free-in-same-cycle accepts");
    chk(64'(log_n - n0), 6, "R5 all stream words stored");
  endtask

  task automatic t_lap();
    logic [PW:0] w0, r0, l, w, r;
    int n;
    mem_gnt = 1'b1;
    rd_stat(6, w0, r0, l);
    n = 16 - int'(5'(w0 - r0));
    for (int k = 0; k < n; k++) begin
      push(6, DW'(16'h6000 + k));
      step();
    end
    repeat (4) step();
    rd_stat(6, w, r, l);
    chk(64'(w), 64'(5'(w0 + n)), "R3 ch6 full");
    chk(64'(ovw_flags), 0, "R6 no lap yet");
    push(6, 16'h6FFF);
    repeat (5) step();
    rd_stat(6, w, r, l);
    chk(64'(ovw_flags), 64'(8'h40), "R6 overwrite flag");
    chk(64'(l), 64'(r0), "R6 saved read pointer");
    chk(64'(r), 64'(5'(r0 + 1)), "R6 read pointer forced on");
    chk(64'(w), 64'(5'(w0 + n + 1)), "R3 write pointer after lap");
    chk(64'(log_a[log_n-1]), 64'({3'd6, 4'(w0 + n)}), "R3 wrapped address");
  endtask

  task automatic t_rp();
    logic [PW:0] w, r0, l, r;
    rd_stat(6, w, r0, l);
    rp_write(6, 5'(r0 + 20));
    rd_stat(6, w, r, l);
    chk(64'(r), 64'(r0), "R7 beyond write pointer ignored");
    rp_write(6, 5'(r0 + 4));
    rd_stat(6, w, r, l);
    chk(64'(r), 64'(5'(r0 + 4)), "R7 inside window taken");
    rp_write(6, w);
    rd_stat(6, w, r, l);
    chk(64'(r), 64'(w), "R7 equal to write pointer taken");
    rp_write(6, 5'(w + 1));
    rd_stat(6, w, r, l);
    chk(64'(r), 64'(w), "R7 one past ignored");
    chk(64'(ovw_flags), 64'(8'h40), "R9 overwrite flag stays");
    clear(8'h00, 8'h40);
    chk(64'(ovw_flags), 0, "R8 overwrite clear");
  endtask

  initial begin
    arst_n = 1'b0; sync_in = 1'b0; mem_gnt = 1'b0; rp_wr_en = 1'b0; clr_en = 1'b0;
    in_valid = '0; in_data = '0; clr_ovf_mask = '0; clr_ovw_mask = '0;
    rp_wr_ch = '0; rp_wr_val = '0; stat_sel = '0;
    repeat (3) step();
    arst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_rr();
    t_tstamp();
    t_ovf();
    t_lap();
    t_rp();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule